// File: doc/BRIEF.md
# General-Purpose I/O Port Bank

This block holds a bank of 8-bit general-purpose I/O ports that a processor controls through a small register bus. Every port has a direction register, a data register and a pull-up register. Writing the data register loads an output latch, and reading it returns the level sampled on the pins. The pull-up register holds one bit for each group of four adjacent pins. Two extra registers control the high-drive outputs. One holds one bit per pin of a single LED-capable port. The other holds one bit per timer output.

On the pad side the block drives output-enable, output value, pull-up enable and high-drive signals for every pin. It samples every pad input through a synchronizer, and the synchronized values go both to register reads and to on-chip peripherals. A peripheral can take over the output of any pin, whatever that pin's direction bit says. One pin, chosen by parameter, is input-only. It never drives and never gets a pull-up.

The register map has a fixed layout. Port p sits at addresses 4p to 4p+3:
- offset 0 is direction (1 = output);
- offset 1 is data;
- offset 2 is pull-up (bit 0 covers pins 3..0, bit 1 covers pins 7..4);
- offset 3 is unused.

The LED drive register sits at address 4·NUM_PORTS. The timer drive register is at the next address.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted and right after it is released, every direction, output-latch, pull-up and drive bit is zero. So padOe, padOut, padPullUp, padHighDrive and timerHighDrive are all zero, and the direction registers read zero.
- R2: A write to a port's direction register (offset 0) sets each bit as that pin's direction, 1 meaning output. It shows on padOe from the next cycle, and the register reads back the written value.
- R3: A write to a data register (offset 1) loads the output latch, and the latch value appears on padOut for that port. A read of offset 1 returns the synchronized pad levels, not the latch.
- R4: Pad inputs pass through two flops. A change on padIn shows on data reads and on pinSync after the second rising clock edge, and not after the first.
- R5: Pull-up bit 0 of a port covers pins 3..0 and bit 1 covers pins 7..4. A group's pull-up reaches padPullUp only for pins that are not driving, meaning direction bit 0 and no peripheral override.
- R6: When perOutEn of a pin is 1, padOe of that pin is 1 and padOut equals perOutVal, whatever the direction bit holds.
- R7: pinSync carries the synchronized pad level of every pin to peripherals, independent of the register bus.
- R8: The input-only pin (port IO_PORT, bit IO_BIT; defaults port 3, bit 5) never drives and never gets a pull-up. A write to its direction bit is ignored and that bit reads back zero, while its data bit still reads the pad.
- R9: The LED drive register (address 16 by default) drives padHighDrive for the pins of port LED_PORT (default 2) and reads back as written. The timer drive register (address 17) drives timerHighDrive from its low NUM_TIMERS bits (5), and its upper bits read zero.
- R10: Unused addresses (offset 3 of any port, and anything above the timer drive register) read zero, and writes to them change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| regAddr | input | 5 | Register address for writes and reads |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for regAddr |
| padIn | input | 32 | Raw pad input levels |
| perOutEn | input | 32 | Per-pin peripheral output takeover |
| perOutVal | input | 32 | Per-pin peripheral output value |
| padOe | output | 32 | Per-pin output enable |
| padOut | output | 32 | Per-pin output value |
| padPullUp | output | 32 | Per-pin pull-up enable |
| padHighDrive | output | 32 | Per-pin high-drive enable (LED port only) |
| timerHighDrive | output | 5 | High-drive enable per timer output |
| pinSync | output | 32 | Synchronized pad levels for peripherals |

## Verification
The assertions check several rules on every cycle:
- peripheral takeover of a pin's output;
- no pull-up on any driving pin;
- the input-only pin staying quiet;
- the two-cycle synchronizer delay;
- the effect of direction and timer-drive writes in the cycle after the write.

Only the directed scenarios can show some other behaviour:
- that a data read returns pad levels rather than the latch;
- how the pull-up groups map onto pins;
- the masked readback of the input-only direction bit;
- that unused addresses are truly inert.

These need chosen stimulus and register readback.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int GP_PORTS     = 4;
  localparam int GP_WIDTH     = 8;
  localparam int GP_PINS      = GP_PORTS * GP_WIDTH;
  localparam int GP_GROUP     = 4;
  localparam int GP_GROUPS    = GP_WIDTH / GP_GROUP;
  localparam int GP_TIMERS    = 5;
  localparam int GP_ADDR_W    = 5;
  localparam int GP_PORT_W    = $clog2(GP_PORTS);
  localparam int GP_PORT_SPAN = 4;

  localparam logic [GP_ADDR_W-1:0] GP_PORT_END = GP_ADDR_W'(GP_PORTS * GP_PORT_SPAN);
  localparam logic [GP_ADDR_W-1:0] GP_LED_ADDR = GP_PORT_END;
  localparam logic [GP_ADDR_W-1:0] GP_TMR_ADDR = GP_ADDR_W'(GP_PORTS * GP_PORT_SPAN + 1);

  localparam logic [1:0] OFS_DIR  = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_PULL = 2'd2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DIR,
    RD_DATA,
    RD_PULL,
    RD_LED,
    RD_TMR
  } rdKind_t;

  typedef struct packed {
    logic [GP_PORTS-1:0]  dirWr;
    logic [GP_PORTS-1:0]  dataWr;
    logic [GP_PORTS-1:0]  pullWr;
    logic                 ledWr;
    logic                 tmrWr;
    rdKind_t              rdKind;
    logic [GP_PORT_W-1:0] rdPort;
  } gpStrobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic                 wrEn,
  input  logic [GP_ADDR_W-1:0] regAddr,
  output gpStrobe_t            stb
);
  logic [GP_PORT_W-1:0] portIdx;
  logic [1:0]           regOfs;
  logic                 inPortSpace;

  assign portIdx     = regAddr[GP_PORT_W+1:2];
  assign regOfs      = regAddr[1:0];
  assign inPortSpace = (regAddr < GP_PORT_END);

  always_comb begin
    stb        = '0;
    stb.rdKind = RD_NONE;
    stb.rdPort = portIdx;
    if (inPortSpace) begin
      unique case (regOfs)
        OFS_DIR: begin
          stb.dirWr[portIdx] = wrEn;
          stb.rdKind         = RD_DIR;
        end
        OFS_DATA: begin
          stb.dataWr[portIdx] = wrEn;
          stb.rdKind          = RD_DATA;
        end
        OFS_PULL: begin
          stb.pullWr[portIdx] = wrEn;
          stb.rdKind          = RD_PULL;
        end
        default: stb.rdKind = RD_NONE;
      endcase
    end else if (regAddr == GP_LED_ADDR) begin
      stb.ledWr  = wrEn;
      stb.rdKind = RD_LED;
    end else if (regAddr == GP_TMR_ADDR) begin
      stb.tmrWr  = wrEn;
      stb.rdKind = RD_TMR;
    end
  end
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int IO_PORT     = 3,
  parameter int IO_BIT      = 5,
  parameter int LED_PORT    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpStrobe_t            stb,
  input  logic [GP_WIDTH-1:0]  wrData,
  input  logic [GP_PINS-1:0]   padIn,
  input  logic [GP_PINS-1:0]   perOutEn,
  input  logic [GP_PINS-1:0]   perOutVal,
  output logic [GP_PINS-1:0]   padOe,
  output logic [GP_PINS-1:0]   padOut,
  output logic [GP_PINS-1:0]   padPullUp,
  output logic [GP_PINS-1:0]   padHighDrive,
  output logic [GP_TIMERS-1:0] timerHighDrive,
  output logic [GP_PINS-1:0]   pinSync,
  output logic [GP_WIDTH-1:0]  rdData
);
  localparam int IO_POS = IO_PORT * GP_WIDTH + IO_BIT;
  localparam logic [GP_PINS-1:0] IO_MASK = GP_PINS'(1) << IO_POS;

  logic [GP_PINS-1:0]            dirFlat;
  logic [GP_PINS-1:0]            latchFlat;
  logic [GP_PINS-1:0]            pullFlat;
  logic [GP_PORTS*GP_GROUPS-1:0] pullAll;
  logic [GP_WIDTH-1:0]           ledQ;
  logic [GP_TIMERS-1:0]          tmrQ;
  logic [GP_PINS-1:0]            syncQ [SYNC_STAGES];
  logic [GP_PINS-1:0]            driving;

  for (genvar p = 0; p < GP_PORTS; p++) begin : g_port
    localparam logic [GP_WIDTH-1:0] FIXED_IN =
      (p == IO_PORT) ? GP_WIDTH'(1 << IO_BIT) : '0;
    logic [GP_WIDTH-1:0]  dirQ;
    logic [GP_WIDTH-1:0]  latchQ;
    logic [GP_GROUPS-1:0] pullQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ   <= '0;
        latchQ <= '0;
        pullQ  <= '0;
      end else begin
        if (stb.dirWr[p])  dirQ   <= wrData & ~FIXED_IN;
        if (stb.dataWr[p]) latchQ <= wrData;
        if (stb.pullWr[p]) pullQ  <= wrData[GP_GROUPS-1:0];
      end
    end

    assign dirFlat[p*GP_WIDTH +: GP_WIDTH]     = dirQ;
    assign latchFlat[p*GP_WIDTH +: GP_WIDTH]   = latchQ;
    assign pullAll[p*GP_GROUPS +: GP_GROUPS]   = pullQ;

    for (genvar g = 0; g < GP_GROUPS; g++) begin : g_grp
      assign pullFlat[p*GP_WIDTH + g*GP_GROUP +: GP_GROUP] = {GP_GROUP{pullQ[g]}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledQ <= '0;
      tmrQ <= '0;
    end else begin
      if (stb.ledWr) ledQ <= wrData;
      if (stb.tmrWr) tmrQ <= wrData[GP_TIMERS-1:0];
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= padIn;
      else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  assign pinSync   = syncQ[SYNC_STAGES-1];
  assign driving   = (dirFlat | perOutEn) & ~IO_MASK;
  assign padOe     = driving;
  assign padOut    = ((perOutEn & perOutVal) | (~perOutEn & latchFlat)) & ~IO_MASK;
  assign padPullUp = pullFlat & ~driving & ~IO_MASK;

  always_comb begin
    padHighDrive = '0;
    padHighDrive[LED_PORT*GP_WIDTH +: GP_WIDTH] = ledQ;
  end
  assign timerHighDrive = tmrQ;

  always_comb begin
    unique case (stb.rdKind)
      RD_DIR:  rdData = dirFlat[stb.rdPort*GP_WIDTH +: GP_WIDTH];
      RD_DATA: rdData = pinSync[stb.rdPort*GP_WIDTH +: GP_WIDTH];
      RD_PULL: rdData = {{(GP_WIDTH-GP_GROUPS){1'b0}},
                         pullAll[stb.rdPort*GP_GROUPS +: GP_GROUPS]};
      RD_LED:  rdData = ledQ;
      RD_TMR:  rdData = {{(GP_WIDTH-GP_TIMERS){1'b0}}, tmrQ};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int IO_PORT     = 3,
  parameter int IO_BIT      = 5,
  parameter int LED_PORT    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [GP_ADDR_W-1:0] regAddr,
  input  logic [GP_WIDTH-1:0]  wrData,
  output logic [GP_WIDTH-1:0]  rdData,
  input  logic [GP_PINS-1:0]   padIn,
  input  logic [GP_PINS-1:0]   perOutEn,
  input  logic [GP_PINS-1:0]   perOutVal,
  output logic [GP_PINS-1:0]   padOe,
  output logic [GP_PINS-1:0]   padOut,
  output logic [GP_PINS-1:0]   padPullUp,
  output logic [GP_PINS-1:0]   padHighDrive,
  output logic [GP_TIMERS-1:0] timerHighDrive,
  output logic [GP_PINS-1:0]   pinSync
);
  gpStrobe_t stb;

  gpio_bank_ctrl ctrl_i (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  gpio_bank_datapath #(
    .IO_PORT     (IO_PORT),
    .IO_BIT      (IO_BIT),
    .LED_PORT    (LED_PORT),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .wrData         (wrData),
    .padIn          (padIn),
    .perOutEn       (perOutEn),
    .perOutVal      (perOutVal),
    .padOe          (padOe),
    .padOut         (padOut),
    .padPullUp      (padPullUp),
    .padHighDrive   (padHighDrive),
    .timerHighDrive (timerHighDrive),
    .pinSync        (pinSync),
    .rdData         (rdData)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int IO_PORT     = 3,
  parameter int IO_BIT      = 5,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [GP_ADDR_W-1:0] regAddr,
  input logic [GP_WIDTH-1:0]  wrData,
  input logic [GP_PINS-1:0]   padIn,
  input logic [GP_PINS-1:0]   perOutEn,
  input logic [GP_PINS-1:0]   perOutVal,
  input logic [GP_PINS-1:0]   padOe,
  input logic [GP_PINS-1:0]   padOut,
  input logic [GP_PINS-1:0]   padPullUp,
  input logic [GP_TIMERS-1:0] timerHighDrive,
  input logic [GP_PINS-1:0]   pinSync
);
  localparam int IO_POS = IO_PORT * GP_WIDTH + IO_BIT;
  localparam logic [GP_WIDTH-1:0] PORT0_FIXED =
    (IO_PORT == 0) ? GP_WIDTH'(1 << IO_BIT) : '0;
  localparam logic [GP_PINS-1:0] IO_MASK = GP_PINS'(1) << IO_POS;

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R6: takeover forces drive and value on every non-fixed pin
  p_override_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | IO_MASK) & perOutEn) == perOutEn &&
    ((padOut ^ perOutVal) & perOutEn & ~IO_MASK) == '0);

  // R5: no pin that drives ever has a pull-up
  p_pull_not_driving_r5: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padOe) == '0);

  // R8: input-only pin is quiet
  p_input_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !padOe[IO_POS] && !padPullUp[IO_POS] && !padOut[IO_POS]);

  // R2: port 0 direction write visible on the next cycle
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == '0) |=>
      (perOutEn[GP_WIDTH-1:0] != '0 ||
       padOe[GP_WIDTH-1:0] == ($past(wrData) & ~PORT0_FIXED)));

  // R9: timer drive follows a write to its register
  p_timer_drive_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == GP_TMR_ADDR) |=>
      timerHighDrive == $past(wrData[GP_TIMERS-1:0]));

  if (SYNC_STAGES == 2) begin : g_sync_chk
    // R4: two-stage delay of pad levels
    p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt >= 2'd2) |-> pinSync == $past(padIn, 2));
  end
endmodule

bind gpio_bank gpio_bank_chk #(
  .IO_PORT     (IO_PORT),
  .IO_BIT      (IO_BIT),
  .SYNC_STAGES (SYNC_STAGES)
) chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .wrEn           (wrEn),
  .regAddr        (regAddr),
  .wrData         (wrData),
  .padIn          (padIn),
  .perOutEn       (perOutEn),
  .perOutVal      (perOutVal),
  .padOe          (padOe),
  .padOut         (padOut),
  .padPullUp      (padPullUp),
  .timerHighDrive (timerHighDrive),
  .pinSync        (pinSync)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  import gpio_bank_pkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 wrEn = 1'b0;
  logic [GP_ADDR_W-1:0] regAddr = '0;
  logic [GP_WIDTH-1:0]  wrData = '0;
  logic [GP_WIDTH-1:0]  rdData;
  logic [GP_PINS-1:0]   padIn = '0;
  logic [GP_PINS-1:0]   perOutEn = '0;
  logic [GP_PINS-1:0]   perOutVal = '0;
  logic [GP_PINS-1:0]   padOe, padOut, padPullUp, padHighDrive, pinSync;
  logic [GP_TIMERS-1:0] timerHighDrive;

  int checks = 0;
  int errors = 0;
  logic [GP_WIDTH-1:0] rd;

  always #2 clk = ~clk;

  gpio_bank dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .regAddr        (regAddr),
    .wrData         (wrData),
    .rdData         (rdData),
    .padIn          (padIn),
    .perOutEn       (perOutEn),
    .perOutVal      (perOutVal),
    .padOe          (padOe),
    .padOut         (padOut),
    .padPullUp      (padPullUp),
    .padHighDrive   (padHighDrive),
    .timerHighDrive (timerHighDrive),
    .pinSync        (pinSync)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [GP_ADDR_W-1:0] a, input logic [GP_WIDTH-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [GP_ADDR_W-1:0] a, output logic [GP_WIDTH-1:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic t_reset();
    check("R1 padOe", padOe, 32'h0);
    check("R1 padOut", padOut, 32'h0);
    check("R1 padPullUp", padPullUp, 32'h0);
    check("R1 padHighDrive", padHighDrive, 32'h0);
    check("R1 timerHighDrive", 32'(timerHighDrive), 32'h0);
    for (int p = 0; p < GP_PORTS; p++) begin
      readReg(GP_ADDR_W'(p*4), rd);
      check("R1 dir readback", 32'(rd), 32'h0);
    end
  endtask

  task automatic t_direction();
    writeReg(5'd4, 8'hA5);
    check("R2 padOe port1", 32'(padOe[15:8]), 32'hA5);
    check("R2 other ports off", padOe & 32'hFFFF00FF, 32'h0);
    readReg(5'd4, rd);
    check("R2 dir readback", 32'(rd), 32'hA5);
  endtask

  task automatic t_data();
    writeReg(5'd5, 8'h3C);
    check("R3 latch on padOut", 32'(padOut[15:8]), 32'h3C);
    padIn[15:8] = 8'h81;
    repeat (2) @(posedge clk);
    readReg(5'd5, rd);
    check("R3 read returns pins", 32'(rd), 32'h81);
    check("R3 latch kept", 32'(padOut[15:8]), 32'h3C);
    padIn[15:8] = 8'h00;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_sync();
    @(negedge clk);
    regAddr = 5'd1;
    padIn[7:0] = 8'h5A;
    @(posedge clk); #1;
    check("R4 after one edge", 32'(rdData), 32'h00);
    @(posedge clk); #1;
    check("R4 after two edges", 32'(rdData), 32'h5A);
    padIn[7:0] = 8'h00;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_pull();
    writeReg(5'd8, 8'h0F);
    writeReg(5'd10, 8'h03);
    check("R5 only input pins pulled", 32'(padPullUp[23:16]), 32'hF0);
    writeReg(5'd10, 8'h01);
    check("R5 low group all outputs", 32'(padPullUp[23:16]), 32'h00);
    writeReg(5'd8, 8'h00);
    check("R5 low group as inputs", 32'(padPullUp[23:16]), 32'h0F);
    readReg(5'd10, rd);
    check("R5 pull readback", 32'(rd), 32'h01);
    writeReg(5'd2, 8'h01);
    check("R5 port0 low group", 32'(padPullUp[7:0]), 32'h0F);
    @(negedge clk);
    perOutEn[0] = 1'b1;
    #1 check("R5 taken-over pin loses pull", 32'(padPullUp[7:0]), 32'h0E);
    perOutEn[0] = 1'b0;
  endtask

  task automatic t_override();
    @(negedge clk);
    perOutEn[15:8] = 8'h0F;
    perOutVal[15:8] = 8'h0A;
    #1;
    check("R6 oe with takeover", 32'(padOe[15:8]), 32'hAF);
    check("R6 value with takeover", 32'(padOut[15:8]), 32'h3A);
    perOutEn = '0;
    perOutVal = '0;
  endtask

  task automatic t_periph_in();
    @(negedge clk);
    padIn[7:0] = 8'hC3;
    repeat (2) @(posedge clk);
    #1 check("R7 pinSync", 32'(pinSync[7:0]), 32'hC3);
    padIn[7:0] = 8'h00;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_input_only();
    writeReg(5'd12, 8'hFF);
    readReg(5'd12, rd);
    check("R8 dir bit masked", 32'(rd), 32'hDF);
    check("R8 oe masked", 32'(padOe[31:24]), 32'hDF);
    writeReg(5'd12, 8'h00);
    writeReg(5'd14, 8'h03);
    check("R8 no pull", 32'(padPullUp[31:24]), 32'hDF);
    @(negedge clk);
    perOutEn[29] = 1'b1;
    perOutVal[29] = 1'b1;
    padIn[29] = 1'b1;
    #1;
    check("R8 takeover ignored oe", 32'(padOe[29]), 32'h0);
    check("R8 takeover ignored val", 32'(padOut[29]), 32'h0);
    repeat (2) @(posedge clk);
    readReg(5'd13, rd);
    check("R8 data still reads pad", 32'(rd), 32'h20);
    perOutEn = '0;
    perOutVal = '0;
    padIn = '0;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_drive();
    writeReg(5'd16, 8'h96);
    check("R9 led high drive", padHighDrive, 32'h0096_0000);
    readReg(5'd16, rd);
    check("R9 led readback", 32'(rd), 32'h96);
    writeReg(5'd17, 8'hFF);
    check("R9 timer high drive", 32'(timerHighDrive), 32'h1F);
    readReg(5'd17, rd);
    check("R9 timer readback", 32'(rd), 32'h1F);
  endtask

  task automatic t_unmapped();
    logic [GP_PINS-1:0] oeBefore;
    oeBefore = padOe;
    writeReg(5'd3, 8'hFF);
    writeReg(5'd18, 8'hFF);
    readReg(5'd3, rd);
    check("R10 gap reads zero", 32'(rd), 32'h0);
    readReg(5'd18, rd);
    check("R10 high address reads zero", 32'(rd), 32'h0);
    readReg(5'd0, rd);
    check("R10 dir0 untouched", 32'(rd), 32'h0);
    readReg(5'd16, rd);
    check("R10 led untouched", 32'(rd), 32'h96);
    check("R10 pads untouched", padOe, oeBefore);
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset_during();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_data();
    t_sync();
    t_pull();
    t_override();
    t_periph_in();
    t_input_only();
    t_drive();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_during();
    check("R1 oe in reset", padOe, 32'h0);
    check("R1 pinSync in reset", pinSync, 32'h0);
  endtask
endmodule